// File: doc/BRIEF.md
# Codec Control Command SPI Sequencer

This block turns single register accesses from an on-chip client into framed control transactions for an external audio decoder that sits on a shared SPI bus. The client presents an operation (write or read), a 4-bit register number and a 16-bit value on a valid/ready handshake. The sequencer waits for the decoder's ready line, then drives a four-byte command under its own command chip select. It waits out a settle interval, waits for the ready line once more, and finally pulses a done strobe. On a read, the strobe comes with the 16-bit word the decoder returned.

The decoder has a second chip select for its audio stream. This block never asserts it and holds it high, so the two selects can never be low together. The decoder has sixteen 16-bit registers. Typical targets are the mode word at 0x0, the clock word at 0x3 and the volume word at 0xB. In the volume word the high byte sets the left channel and the low byte sets the right channel. The block passes the data through unchanged and attaches no meaning to any register.

The SCK rate is set by a divider parameter. The settle interval is a cycle-count parameter, and its default is 5 ms at a 200 MHz clock. The ready line from the device is brought through a two-stage synchronizer before the block uses it.

Top module: `codec_cmd_seq`

## Requirements
- R1: Every command is 32 bits long, made of four bytes. The first byte is the opcode: 0x02 for a write and 0x03 for a read. The second byte is the register number in its low four bits, with the upper four bits zero. The third and fourth bytes are the data word, high byte first. On a read, the two data bytes are sent as zero.
- R2: Bits go out most significant first in SPI mode 0. SCK idles low. MOSI changes only while SCK is low. Each SCK half period lasts CLK_DIV clock cycles.
- R3: cmd_cs_n is low only while a command is being shifted. During each low period it carries exactly 32 SCK rising edges, and it returns high together with the final SCK falling edge.
- R4: dat_cs_n stays high at all times, so the two chip selects are never low together.
- R5: cmd_cs_n does not fall until the synchronized dev_ready input is high. A command accepted while dev_ready is low waits without touching the bus.
- R6: After cmd_cs_n returns high, rsp_valid is withheld for at least SETTLE_CYCLES clock cycles.
- R7: When the settle interval ends, rsp_valid is withheld until the synchronized dev_ready is high again.
- R8: For a read, rsp_rdata holds the 16 MISO bits sampled on the SCK rising edges of the two data bytes, with the first byte in bits 15:8. For a write, rsp_rdata is zero. The value is valid while rsp_valid is high and holds until the next command completes.
- R9: req_ready is high only while the block is idle, and a command is accepted on a clock edge where req_valid and req_ready are both high. A req_valid presented while busy has no effect: it starts no transaction.
- R10: busy goes high in the cycle after acceptance and stays high until done. rsp_valid is a one-cycle pulse, and busy is low in that same cycle.
- R11: After reset the outputs are as follows: cmd_cs_n and dat_cs_n high, spi_sck low, busy and rsp_valid low, and req_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Block idle; ready to accept a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Decoder register number |
| req_wdata | input | 16 | Write data (ignored on reads) |
| rsp_valid | output | 1 | One-cycle done strobe |
| rsp_rdata | output | 16 | Read result (zero after a write) |
| busy | output | 1 | Command in progress |
| dev_ready | input | 1 | Decoder ready line (asynchronous) |
| spi_sck | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data to the decoder |
| spi_miso | input | 1 | SPI data from the decoder |
| cmd_cs_n | output | 1 | Command chip select, active low |
| dat_cs_n | output | 1 | Audio-stream chip select, held high |

## Verification
Two behaviours are hard to see from the ports. The first is the gap between the end of the frame and the done strobe. In that gap the bus is quiet and only the settle count and the second ready check decide when done appears. The bench watches cmd_cs_n rise, then counts clock cycles to rsp_valid while dev_ready stays high. In a second run it drops dev_ready just after the chip select releases and holds it low well past the settle count, which shows that done waits on the ready line. A device model that shifts its response on SCK falling edges lets the bench tell a correctly placed read capture apart from one shifted by a bit.

// File: rtl/codec_cmd_pkg.sv
package codec_cmd_pkg;
  localparam int CMD_ADDR_W = 4;
  localparam int CMD_DATA_W = 16;
  localparam int BYTE_W     = 8;
  localparam int FRAME_W    = 4 * BYTE_W;

  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h02;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h03;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_PRE,
    S_SHIFT,
    S_SETTLE,
    S_WAIT_POST
  } seq_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0]     opcode;
    logic [BYTE_W-1:0]     reg_byte;
    logic [CMD_DATA_W-1:0] data;
  } cmd_frame_t;

  // Assemble the 32-bit command frame; reads carry zero data bytes.
  function automatic cmd_frame_t build_frame(input logic is_write,
                                             input logic [CMD_ADDR_W-1:0] addr,
                                             input logic [CMD_DATA_W-1:0] wdata);
    cmd_frame_t f;
    f.opcode   = is_write ? OP_WRITE : OP_READ;
    f.reg_byte = {{(BYTE_W-CMD_ADDR_W){1'b0}}, addr};
    f.data     = is_write ? wdata : '0;
    return f;
  endfunction

  // The last two bytes clocked in form the read word, first byte high.
  function automatic logic [CMD_DATA_W-1:0] read_word(input logic [FRAME_W-1:0] rx);
    return rx[CMD_DATA_W-1:0];
  endfunction

  // Width of a counter that must reach value n.
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n + 1) : 1;
  endfunction
endpackage

// File: rtl/codec_cmd_sync.sv
module codec_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/codec_cmd_shift.sv
module codec_cmd_shift
  import codec_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int NBITS   = FRAME_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NBITS-1:0] frame_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             active_o,
  output logic             done_o,
  output logic [NBITS-1:0] rx_o
);
  localparam int DIV_W = cnt_width(CLK_DIV);
  localparam int BIT_W = cnt_width(NBITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NBITS - 1);

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [NBITS-1:0] tx_q, rx_q;
  logic             sck_q, active_q;

  // Half-period boundary of SCK: the only cycle any bus state changes.
  logic half_tick;
  assign half_tick = active_q && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sck_q    <= 1'b0;
      active_q <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_q     <= frame_i;
          rx_q     <= '0;
          div_q    <= '0;
          bit_q    <= '0;
          sck_q    <= 1'b0;
        end
      end else if (half_tick) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= {rx_q[NBITS-2:0], miso_i};
        end else begin
          sck_q <= 1'b0;
          if (bit_q == BIT_LAST) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[NBITS-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = tx_q[NBITS-1];
  assign active_o = active_q;
  assign rx_o     = rx_q;
endmodule

// File: rtl/codec_cmd_settle.sv
module codec_cmd_settle
  import codec_cmd_pkg::*;
#(
  parameter int CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = cnt_width(CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q <= LOAD;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/codec_cmd_seq.sv
module codec_cmd_seq
  import codec_cmd_pkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int SETTLE_CYCLES = 1_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [CMD_ADDR_W-1:0] req_addr,
  input  logic [CMD_DATA_W-1:0] req_wdata,
  output logic                  rsp_valid,
  output logic [CMD_DATA_W-1:0] rsp_rdata,
  output logic                  busy,
  input  logic                  dev_ready,
  output logic                  spi_sck,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic                  cmd_cs_n,
  output logic                  dat_cs_n
);
  seq_state_t           state_q, state_nx;
  cmd_frame_t           frame_q;
  logic                 is_read_q;
  logic                 rdy_sync;
  logic                 shift_active, shift_done;
  logic [FRAME_W-1:0]   shift_rx;
  logic                 settle_done;

  // Named internal events
  logic accept_evt, launch_evt, finish_evt, in_shift;
  assign accept_evt = req_valid && req_ready;
  assign launch_evt = (state_q == S_WAIT_PRE) && rdy_sync;
  assign finish_evt = (state_q == S_WAIT_POST) && rdy_sync;
  assign in_shift   = (state_q == S_SHIFT);

  codec_cmd_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d_i(dev_ready), .q_o(rdy_sync)
  );

  codec_cmd_shift #(.CLK_DIV(CLK_DIV), .NBITS(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_i(launch_evt), .frame_i(frame_q),
    .miso_i(spi_miso), .sck_o(spi_sck), .mosi_o(spi_mosi),
    .active_o(shift_active), .done_o(shift_done), .rx_o(shift_rx)
  );

  codec_cmd_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .start_i(shift_done), .done_o(settle_done)
  );

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      S_IDLE:      if (accept_evt)  state_nx = S_WAIT_PRE;
      S_WAIT_PRE:  if (rdy_sync)    state_nx = S_SHIFT;
      S_SHIFT:     if (shift_done)  state_nx = S_SETTLE;
      S_SETTLE:    if (settle_done) state_nx = S_WAIT_POST;
      S_WAIT_POST: if (rdy_sync)    state_nx = S_IDLE;
      default:                      state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      frame_q   <= '0;
      is_read_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q   <= state_nx;
      rsp_valid <= finish_evt;
      if (accept_evt) begin
        frame_q   <= build_frame(req_write, req_addr, req_wdata);
        is_read_q <= !req_write;
      end
      if (finish_evt) rsp_rdata <= is_read_q ? read_word(shift_rx) : '0;
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign cmd_cs_n  = !shift_active;
  assign dat_cs_n  = 1'b1;
endmodule

// File: rtl/codec_cmd_seq_chk.sv
module codec_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic rsp_valid,
  input logic cmd_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic rdy_sync,
  input logic in_shift
);
  // R3
  cs_in_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cs_n |-> in_shift);
  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cs_n |-> !spi_sck);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
  // R5
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_cs_n) |-> $past(rdy_sync));
  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rdy_sync));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!busy && req_ready));
  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
endmodule

bind codec_cmd_seq codec_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .rsp_valid(rsp_valid), .cmd_cs_n(cmd_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .rdy_sync(rdy_sync), .in_shift(in_shift)
);

// File: tb/codec_cmd_seq_test.sv
`timescale 1ns/1ps
module codec_cmd_seq_test;
  localparam int CLK_DIV = 3;
  localparam int SETTLE  = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy;
  logic [15:0] rsp_rdata;
  logic dev_ready = 1'b0;
  logic spi_sck, spi_mosi, cmd_cs_n, dat_cs_n;
  logic spi_miso = 1'b0;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // device model state
  logic [31:0] slv_resp = '0;
  logic [31:0] cap_word = '0, s_word;
  int cap_bits = 0, s_bits, xfer_cnt = 0, dat_viol = 0;
  realtime t1, gap = 0.0;
  logic [15:0] got_rdata;

  always #2.5 clk = ~clk;

  codec_cmd_seq #(.CLK_DIV(CLK_DIV), .SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .dev_ready(dev_ready), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .cmd_cs_n(cmd_cs_n), .dat_cs_n(dat_cs_n)
  );

  // SPI device model: capture MOSI on SCK rise, shift response on SCK fall
  initial begin
    forever begin
      @(negedge cmd_cs_n);
      s_bits = 0;
      s_word = '0;
      #1 spi_miso = slv_resp[31];
      forever begin
        @(posedge spi_sck or posedge cmd_cs_n);
        #1;
        if (cmd_cs_n) break;
        s_word = {s_word[30:0], spi_mosi};
        s_bits++;
        if (s_bits == 1) t1 = $realtime;
        if (s_bits == 2) gap = $realtime - t1;
        if (!dat_cs_n) dat_viol++;
        @(negedge spi_sck or posedge cmd_cs_n);
        #1;
        if (cmd_cs_n) break;
        if (s_bits < 32) spi_miso = slv_resp[31 - s_bits];
      end
      cap_word = s_word;
      cap_bits = s_bits;
      xfer_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        seen = 1;
        got_rdata = rsp_rdata;
        break;
      end
    end
  endtask

  task automatic wait_cs_release();
    while (cmd_cs_n) @(negedge clk);
    while (!cmd_cs_n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cmd_cs_n == 1'b1, "R11 cmd_cs_n", cmd_cs_n, 1);
    chk(dat_cs_n == 1'b1, "R11 dat_cs_n", dat_cs_n, 1);
    chk(spi_sck == 1'b0, "R11 sck", spi_sck, 0);
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(rsp_valid == 1'b0, "R11 rsp_valid", rsp_valid, 0);
    chk(req_ready == 1'b1, "R11 req_ready", req_ready, 1);
  endtask

  task automatic t_write_volume();
    bit seen;
    int x0 = xfer_cnt;
    dev_ready = 1'b1;
    issue(1'b1, 4'hB, 16'hA55A);
    wait_done(seen);
    chk(seen, "R10 done seen", seen, 1);
    chk(cap_word == 32'h020BA55A, "R1 write frame", cap_word, 32'h020BA55A);
    chk(cap_bits == 32, "R3 bit count", cap_bits, 32);
    chk(gap > 29.9 && gap < 30.1, "R2 sck period ns", int'(gap), 30);
    chk(got_rdata == 16'h0, "R8 write rdata", got_rdata, 0);
    chk(dat_viol == 0, "R4 dat_cs_n high", dat_viol, 0);
    chk(xfer_cnt == x0 + 1, "R3 one select", xfer_cnt - x0, 1);
    chk(busy == 1'b0, "R10 busy after done", busy, 0);
  endtask

  task automatic t_read();
    bit seen;
    slv_resp = 32'h5A5ABEEF;
    issue(1'b0, 4'h3, 16'hFFFF);
    wait_done(seen);
    chk(seen, "R10 read done", seen, 1);
    chk(cap_word == 32'h03030000, "R1 read frame", cap_word, 32'h03030000);
    chk(got_rdata == 16'hBEEF, "R8 read data", got_rdata, 16'hBEEF);
    slv_resp = 32'h000000FF;
    issue(1'b0, 4'hB, 16'h0000);
    wait_done(seen);
    chk(got_rdata == 16'h00FF, "R8 read low byte", got_rdata, 16'h00FF);
  endtask

  task automatic t_modes();
    bit seen;
    issue(1'b1, 4'h0, 16'h0820);
    wait_done(seen);
    chk(cap_word == 32'h02000820, "R1 mode frame", cap_word, 32'h02000820);
    issue(1'b1, 4'hF, 16'h8001);
    wait_done(seen);
    chk(cap_word == 32'h020F8001, "R2 msb first frame", cap_word, 32'h020F8001);
  endtask

  task automatic t_ready_gate();
    bit seen;
    int lows = 0, x0 = xfer_cnt;
    @(negedge clk) dev_ready = 1'b0;
    repeat (5) @(negedge clk);
    issue(1'b1, 4'h5, 16'h1234);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!cmd_cs_n) lows++;
    end
    chk(lows == 0, "R5 no select while not ready", lows, 0);
    chk(busy == 1'b1, "R10 busy while waiting", busy, 1);
    chk(xfer_cnt == x0, "R5 no transfer", xfer_cnt - x0, 0);
    dev_ready = 1'b1;
    wait_done(seen);
    chk(seen && cap_word == 32'h02051234, "R5 proceeds after ready", cap_word, 32'h02051234);
  endtask

  task automatic t_settle();
    bit seen;
    int n = 0, early = 0;
    issue(1'b1, 4'h3, 16'h9800);
    wait_cs_release();
    for (int i = 0; i < 200; i++) begin
      n++;
      if (rsp_valid) break;
      @(negedge clk);
    end
    chk(n >= SETTLE && n <= SETTLE + 8, "R6 settle cycles", n, SETTLE);
    issue(1'b1, 4'h3, 16'h9801);
    wait_cs_release();
    dev_ready = 1'b0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (rsp_valid) early++;
    end
    chk(early == 0, "R7 done held while not ready", early, 0);
    dev_ready = 1'b1;
    wait_done(seen);
    chk(seen, "R7 done after ready", seen, 1);
  endtask

  task automatic t_busy_ignore();
    bit seen;
    int rdy_hi = 0, x0 = xfer_cnt;
    issue(1'b1, 4'h7, 16'h0F0F);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h2; req_wdata = 16'hDEAD;
    for (int i = 0; i < 5; i++) begin
      if (req_ready) rdy_hi++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rdy_hi == 0, "R9 ready low while busy", rdy_hi, 0);
    wait_done(seen);
    repeat (150) @(negedge clk);
    chk(xfer_cnt == x0 + 1, "R9 busy request ignored", xfer_cnt - x0, 1);
    chk(cap_word == 32'h02070F0F, "R9 first command kept", cap_word, 32'h02070F0F);
    chk(busy == 1'b0 && req_ready == 1'b1, "R10 idle after", busy, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_volume();
    t_read();
    t_modes();
    t_ready_gate();
    t_settle();
    t_busy_ignore();
    summary();
  end
endmodule